// File: doc/BRIEF.md
# Parallel-Move Limiter and Width Adapter

This block sits on the operand path of a DSP-style parallel data move. Each cycle it may accept one move: a source selector picks a full 56-bit accumulator, one portion of that accumulator, a 24-bit register or memory word, or a 16-bit address register. A destination flag says whether the result lands in a 24-bit location or a 16-bit register. The block forms the destination word and presents it on a 24-bit result bus one clock later, together with a valid strobe.

When a whole accumulator is read, the block checks whether the integer bits above the high word carry significant data. These are the 8 extension bits together with the top bit of the high word. If they are more than a plain sign extension, the block stores a 24-bit saturation constant instead of the high word. It then pulses a per-move limit indication and sets a sticky limit flag. Only an explicit clear input resets that flag. Width adaptation is asymmetric. A 24-bit operand sent to a 16-bit destination is truncated to its low 16 bits. A 16-bit operand sent to a 24-bit destination is zero-extended.

Top module: `pmove_limiter`

## Requirements
- R1: Source code 0 on `src_sel_i` selects the full accumulator (bits 55..48 extension, 47..24 high word, 23..0 low word). If bits 55..47 are all equal, the result is the high word unchanged.
- R2: For source code 0, if bits 55..47 are not all equal, the result is 0x7FFFFF when bit 55 is 0 and 0x800000 when bit 55 is 1.
- R3: `limited_o` is 1 in the output cycle of a move that was saturated under R2, and 0 for every other move and in idle cycles.
- R4: `lim_flag_o` goes to 1 with the first saturated move and stays 1 until `clr_lim_i` is high in a cycle with no saturation. It is 0 from the following output cycle on. A move that does not saturate never clears it.
- R5: When `clr_lim_i` is high in the same cycle as a saturating move, `lim_flag_o` stays 1.
- R6: Source code 1 (extension) gives bits 55..48 sign-extended to 24 bits. Code 2 gives the high word and code 3 gives the low word, both unchanged. None of these is ever limited.
- R7: With `dst_wide_i` = 0 (16-bit destination), `data_o` carries the low 16 bits of the operand in bits 15..0 and zeros in bits 23..16.
- R8: Source code 5 (16-bit address register) with `dst_wide_i` = 1 gives `addr_i` in bits 15..0 and zeros in bits 23..16. Code 4 passes `word_i` unchanged, and codes 6 and 7 behave as code 4.
- R9: After reset `valid_o`, `data_o`, `limited_o` and `lim_flag_o` are 0. A move taken with `valid_i` high appears one clock later with `valid_o` high. In a cycle with `valid_i` low, `data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A move is presented this cycle |
| src_sel_i | input | 3 | Source selector (codes in R1, R6, R8) |
| dst_wide_i | input | 1 | 1 = 24-bit destination, 0 = 16-bit destination |
| acc_i | input | 56 | Accumulator operand |
| word_i | input | 24 | 24-bit register or memory operand |
| addr_i | input | 16 | 16-bit address register operand |
| clr_lim_i | input | 1 | Clears the sticky limit flag |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| data_o | output | 24 | Destination word |
| limited_o | output | 1 | This result was saturated |
| lim_flag_o | output | 1 | Sticky limit flag |

## Verification
Two functions can meet in one cycle: a saturating accumulator move that sets the sticky flag, and a clear request that resets it. The bench provokes this collision on purpose, with a clear driven in the same cycle as an out-of-range accumulator move. It also drives clears next to moves that do not saturate. The behavioural model gives the set priority, so the flag stays high after a collision and falls after a lone clear. Every output is compared against the model each clock, over both directed and random streams.

// File: rtl/pmove_pkg.sv
package pmove_pkg;
  localparam logic [2:0] SRC_ACC  = 3'd0;
  localparam logic [2:0] SRC_EXT  = 3'd1;
  localparam logic [2:0] SRC_HI   = 3'd2;
  localparam logic [2:0] SRC_LO   = 3'd3;
  localparam logic [2:0] SRC_WORD = 3'd4;
  localparam logic [2:0] SRC_ADDR = 3'd5;
endpackage

// File: rtl/pmove_sat.sv
module pmove_sat #(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sat_o
);
  localparam int TOP_LO = 2 * WORD_W - 1;
  logic [ACC_W-1-TOP_LO:0] top;
  logic [WORD_W-1:0] pos_c, neg_c;

  assign top   = acc_i[ACC_W-1:TOP_LO];
  assign pos_c = {1'b0, {(WORD_W-1){1'b1}}};
  assign neg_c = {1'b1, {(WORD_W-1){1'b0}}};
  // integer bits in use when not a pure sign extension
  assign sat_o  = !((&top) || !(|top));
  assign word_o = sat_o ? (acc_i[ACC_W-1] ? neg_c : pos_c)
                        : acc_i[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/pmove_fit.sv
module pmove_fit
  import pmove_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int ADDR_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic [2:0]        src_sel_i,
  input  logic              dst_wide_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [WORD_W-1:0] sat_word_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] op;

  always_comb begin
    case (src_sel_i)
      SRC_ACC:  op = sat_word_i;
      SRC_EXT:  op = {{(WORD_W-EXT_W){acc_i[ACC_W-1]}}, acc_i[ACC_W-1:2*WORD_W]};
      SRC_HI:   op = acc_i[2*WORD_W-1:WORD_W];
      SRC_LO:   op = acc_i[WORD_W-1:0];
      SRC_ADDR: op = {{(WORD_W-ADDR_W){1'b0}}, addr_i};
      default:  op = word_i;
    endcase
  end

  // narrow destination keeps low bits, upper bits zero on the bus
  assign data_o = dst_wide_i ? op : {{(WORD_W-ADDR_W){1'b0}}, op[ADDR_W-1:0]};
endmodule

// File: rtl/pmove_limiter.sv
module pmove_limiter
  import pmove_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24,
  parameter int ADDR_W = 16,
  localparam int ACC_W = EXT_W + 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        src_sel_i,
  input  logic              dst_wide_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_lim_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              limited_o,
  output logic              lim_flag_o
);
  logic [WORD_W-1:0] sat_word, fit_word;
  logic              sat_raw, sat_hit;

  pmove_sat #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_sat (
    .acc_i (acc_i),
    .word_o(sat_word),
    .sat_o (sat_raw)
  );

  pmove_fit #(.EXT_W(EXT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fit (
    .src_sel_i (src_sel_i),
    .dst_wide_i(dst_wide_i),
    .acc_i     (acc_i),
    .sat_word_i(sat_word),
    .word_i    (word_i),
    .addr_i    (addr_i),
    .data_o    (fit_word)
  );

  assign sat_hit = valid_i && (src_sel_i == SRC_ACC) && sat_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      limited_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      limited_o <= sat_hit;
      if (valid_i) data_o <= fit_word;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lim_flag_o <= 1'b0;
    else if (sat_hit)   lim_flag_o <= 1'b1;
    else if (clr_lim_i) lim_flag_o <= 1'b0;
  end

  p_sat_const_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_sel_i == SRC_ACC && dst_wide_i && sat_raw) |=>
      (data_o == {1'b0, {(WORD_W-1){1'b1}}} || data_o == {1'b1, {(WORD_W-1){1'b0}}}));

  p_portion_unlimited_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_sel_i != SRC_ACC) |=> !limited_o);

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_flag_o && !clr_lim_i) |=> lim_flag_o);

  p_clear_works_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lim_i && !sat_hit) |=> !lim_flag_o);

  p_limit_sets_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limited_o |-> lim_flag_o);

  p_narrow_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dst_wide_i) |=> (data_o[WORD_W-1:ADDR_W] == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: tb/sim_pmove_limiter.sv
`timescale 1ns/1ps
module sim_pmove_limiter;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid, dwide, clr;
  logic [2:0]  ssel;
  logic [55:0] acc;
  logic [23:0] wrd;
  logic [15:0] adr;
  logic        v_o, lim_o, flag_o;
  logic [23:0] d_o;

  int checks = 0, failures = 0;
  bit          e_v = 0, e_lim = 0, e_flag = 0;
  logic [23:0] e_d = '0;
  string       e_req = "R9";

  always #2 clk = ~clk;

  pmove_limiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src_sel_i(ssel),
    .dst_wide_i(dwide), .acc_i(acc), .word_i(wrd), .addr_i(adr),
    .clr_lim_i(clr), .valid_o(v_o), .data_o(d_o), .limited_o(lim_o),
    .lim_flag_o(flag_o)
  );

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit [2:0] s, bit w, bit [55:0] a, bit [23:0] wd,
                      bit [15:0] ad, bit c, string req);
    longint sa, ip;
    bit sat;
    logic [23:0] op;
    @(negedge clk);
    chk(e_req, "valid", {23'b0, v_o}, {23'b0, e_v});
    chk(e_req, "data", d_o, e_d);
    chk(e_req, "limited", {23'b0, lim_o}, {23'b0, e_lim});
    chk(e_req, "flag", {23'b0, flag_o}, {23'b0, e_flag});
    valid = v; ssel = s; dwide = w; acc = a; wrd = wd; adr = ad; clr = c;
    sa  = longint'({{8{a[55]}}, a});
    ip  = sa >>> 47;
    sat = v && s == 3'd0 && ip != 0 && ip != -1;
    case (s)
      3'd0: op = sat ? (a[55] ? 24'h800000 : 24'h7fffff) : a[47:24];
      3'd1: op = 24'(signed'(a[55:48]));
      3'd2: op = a[47:24];
      3'd3: op = a[23:0];
      3'd5: op = {8'h00, ad};
      default: op = wd;
    endcase
    if (!w) op = op & 24'h00ffff;
    e_v   = v;
    e_lim = sat;
    if (v) e_d = op;
    if (sat) e_flag = 1;
    else if (c) e_flag = 0;
    e_req = req;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    valid = 0; ssel = 0; dwide = 1; acc = '0; wrd = '0; adr = '0; clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state checked by first step
    step(0, 0, 1, '0, '0, '0, 0, "R9");
    step(1, 0, 1, 56'h00_123456_abcdef, 0, 0, 0, "R1");
    step(1, 0, 1, 56'hff_876543_000001, 0, 0, 0, "R1");
    step(1, 0, 1, 56'h00_800000_000000, 0, 0, 0, "R2");
    step(0, 0, 1, '0, '0, '0, 0, "R4");
    step(1, 0, 1, 56'h3f_123456_000000, 0, 0, 0, "R2");
    step(1, 4, 1, 0, 24'h55aa33, 0, 0, "R4");
    step(1, 0, 1, 56'h00_012345_000000, 0, 0, 1, "R4");
    step(1, 0, 1, 56'h80_000000_000000, 0, 0, 1, "R5");
    step(1, 0, 0, 56'hfe_000000_000000, 0, 0, 1, "R5");
    step(0, 0, 1, '0, '0, '0, 1, "R4");
    step(1, 1, 1, 56'h85_000000_000000, 0, 0, 0, "R6");
    step(1, 1, 1, 56'h7f_ffffff_ffffff, 0, 0, 0, "R6");
    step(1, 2, 1, 56'h5a_abcdef_123456, 0, 0, 0, "R6");
    step(1, 3, 1, 56'h5a_abcdef_123456, 0, 0, 0, "R6");
    step(1, 4, 0, 0, 24'hfedcba, 0, 0, "R7");
    step(1, 2, 0, 56'h00_abcdef_000000, 0, 0, 0, "R7");
    step(1, 5, 1, 0, 0, 16'hbeef, 0, "R8");
    step(1, 6, 1, 0, 24'h123abc, 0, 0, "R8");
    step(1, 7, 0, 0, 24'h9abcde, 0, 0, "R8");
    step(0, 3, 0, 56'h1, 24'h1, 16'h1, 0, "R9");
    for (int i = 0; i < 600; i++) begin
      bit [7:0] ex;
      case ($urandom_range(0, 3))
        0: ex = 8'h00;
        1: ex = 8'hff;
        default: ex = 8'($urandom);
      endcase
      step(($urandom_range(0, 4) != 0), 3'($urandom_range(0, 7)), 1'($urandom),
           {ex, 24'($urandom), 24'($urandom)}, 24'($urandom), 16'($urandom),
           ($urandom_range(0, 5) == 0), "R3");
    end
    step(0, 0, 1, '0, '0, '0, 0, "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule